// File: doc/BRIEF.md
# Enveloped Message Link Receiver

This block terminates the receive end of a 32-bit word link whose sender frames each message with an enable line. The enable rises with the first word of a message. It falls during the final word, which still belongs to the message. Because of this, a following message can start on the very next word. The receiver captures data and enable on the falling edge of the link clock and works out from the enable history which words are payload, which is first and which is last. It then pushes each word, tagged with those two markers, into a receive queue.

The local side drains the queue through a show-ahead read port that carries first and last flags beside each data word. The block drives a flow-control line back to the sender. The line is high (go) only while the queue has room for a complete maximum-size message of four header words and sixty-four payload words. A sender that checks the line before starting a message can therefore always finish that message. Words that arrive while the queue is completely full are discarded and raise a sticky error flag.

Top module: `emsg_link_rx`

## Requirements
- R1: Data and enable are captured on the falling edge of `clk`. A data value present only around that edge is the value stored.
- R2: A word whose enable sample is high while the previous sample was low is stored with `rd_first` = 1.
- R3: The word whose enable sample is low while the previous sample was high is stored as the final word of the message, with `rd_last` = 1. Words in between carry neither flag.
- R4: When the enable returns high on the word right after a final word, that word begins a new message with its own first flag, and both messages are stored complete.
- R5: While the enable is low and was low on the previous sample, nothing is written to the queue.
- R6: `lnk_fc` is 0 (stop) whenever the queue has fewer free entries than one maximum message (HDR_MAX + PAY_MAX = 68 words). Otherwise it is 1. With DEPTH = 128, an occupancy of 60 gives 1 and an occupancy of 61 or more gives 0.
- R7: The read port is first-in first-out. `rd_vld` is high while the queue is non-empty. `rd_data`, `rd_first` and `rd_last` show the oldest word, and `rd_en` with `rd_vld` removes it at the rising edge.
- R8: A word that arrives while the queue holds DEPTH words and no word is read in that cycle is dropped, and `ovf_err` goes to 1. `ovf_err` stays 1 until `ovf_clr` is pulsed. A drop in the same cycle as the clear keeps it set.
- R9: Reset (`rst_n` low, asynchronous) empties the queue, clears `ovf_err` and drives `lnk_fc` to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Link clock; link signals sampled on its falling edge, queue updated on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lnk_den | input | 1 | Message envelope enable from the sender |
| lnk_dat | input | 32 | Link data word |
| lnk_fc | output | 1 | Flow control to sender: 1 = send allowed, 0 = stop |
| rd_en | input | 1 | Read strobe; removes the presented word when `rd_vld` is high |
| rd_vld | output | 1 | Queue holds at least one word |
| rd_data | output | 32 | Oldest stored word |
| rd_first | output | 1 | Oldest word opens a message |
| rd_last | output | 1 | Oldest word closes a message |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| ovf_err | output | 1 | Sticky flag: a word was dropped because the queue was full |

## Verification
A wrong edge history in the sampler shows up as a missing or misplaced first or last flag. The bench sees it on the first read of the affected message, one rising edge after the final word is sampled. A wrong occupancy count moves the stop/go threshold of `lnk_fc`, which becomes visible on the next falling edge after the write that crosses 60 words. It also changes how many words can be drained before `rd_vld` drops. A broken drop path either leaves `ovf_err` low after a 130-word burst, or lets the tail words overwrite stored ones so that the drained data sequence no longer ends at the 128th word.

// File: rtl/link_rx_pkg.sv
`timescale 1ns/1ps
package link_rx_pkg;

  // classification of one sampled link word
  typedef struct packed {
    logic valid;
    logic first;
    logic last;
  } wkind_t;

  // word flags carried through the queue
  typedef struct packed {
    logic first;
    logic last;
  } mark_t;

  // decide what the current enable sample means given the previous one
  function automatic wkind_t classify(logic cur, logic prev);
    wkind_t k;
    k.valid = cur | prev;
    k.first = cur & ~prev;
    k.last  = ~cur & prev;
    return k;
  endfunction

  function automatic int unsigned room_left(int unsigned depth, int unsigned used);
    return (used >= depth) ? 0 : depth - used;
  endfunction

  function automatic logic room_for_msg(int unsigned room, int unsigned msg_words);
    return room >= msg_words;
  endfunction

endpackage

// File: rtl/lrx_sampler.sv
`timescale 1ns/1ps
module lrx_sampler
  import link_rx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lnk_den,
  input  logic [DATA_W-1:0] lnk_dat,
  output logic              wr_vld,
  output mark_t             wr_mark,
  output logic [DATA_W-1:0] wr_data
);

  logic              s_den;
  logic              s_prev;
  logic [DATA_W-1:0] s_dat;
  wkind_t            kind;

  // capture on the falling edge of the link clock
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_den  <= 1'b0;
      s_prev <= 1'b0;
      s_dat  <= '0;
    end else begin
      s_prev <= s_den;
      s_den  <= lnk_den;
      s_dat  <= lnk_dat;
    end
  end

  always_comb begin
    kind          = classify(s_den, s_prev);
    wr_vld        = kind.valid;
    wr_mark.first = kind.first;
    wr_mark.last  = kind.last;
    wr_data       = s_dat;
  end

  // R2
  first_single_chk: assert property (@(negedge clk) disable iff (!rst_n)
    wr_mark.first |=> !wr_mark.first);

  // R3
  last_after_word_chk: assert property (@(negedge clk) disable iff (!rst_n)
    wr_mark.last |-> $past(wr_vld) && !$past(wr_mark.last));

endmodule

// File: rtl/lrx_queue.sv
`timescale 1ns/1ps
module lrx_queue
  import link_rx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  mark_t              push_mark,
  input  logic [DATA_W-1:0]  push_data,
  input  logic               pop_req,
  input  logic               ovf_clr,
  output logic               q_vld,
  output mark_t              q_mark,
  output logic [DATA_W-1:0]  q_data,
  output logic [$clog2(DEPTH+1)-1:0] used,
  output logic               ovf
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int ENT_W = DATA_W + 2;

  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic             full, empty;
  logic             do_push, do_pop, drop;

  function automatic logic [PTR_W-1:0] ptr_next(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (used == CNT_W'(DEPTH));
  assign empty   = (used == '0);
  assign do_pop  = pop_req && !empty;
  assign do_push = push && (!full || do_pop);
  assign drop    = push && !do_push;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= {push_mark.first, push_mark.last, push_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      used <= '0;
      ovf  <= 1'b0;
    end else begin
      if (do_push) wp <= ptr_next(wp);
      if (do_pop)  rp <= ptr_next(rp);
      case ({do_push, do_pop})
        2'b10:   used <= used + 1'b1;
        2'b01:   used <= used - 1'b1;
        default: used <= used;
      endcase
      if (drop)         ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
    end
  end

  assign q_vld        = !empty;
  assign q_mark.first = mem[rp][ENT_W-1];
  assign q_mark.last  = mem[rp][ENT_W-2];
  assign q_data       = mem[rp][DATA_W-1:0];

  // R7
  used_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    used <= CNT_W'(DEPTH));

  // R7
  pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && q_vld && !push) |=> used == $past(used) - 1'b1);

  // R8
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && used == CNT_W'(DEPTH) && !pop_req) |=> ovf && $stable(used));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf);

endmodule

// File: rtl/lrx_flow.sv
`timescale 1ns/1ps
module lrx_flow
  import link_rx_pkg::*;
#(
  parameter int DEPTH     = 128,
  parameter int MSG_WORDS = 68
) (
  input  logic [$clog2(DEPTH+1)-1:0] used,
  output logic                       xon
);

  always_comb begin
    xon = room_for_msg(room_left(DEPTH, 32'(used)), MSG_WORDS);
  end

endmodule

// File: rtl/emsg_link_rx.sv
`timescale 1ns/1ps
module emsg_link_rx
  import link_rx_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int HDR_MAX = 4,
  parameter int PAY_MAX = 64,
  parameter int DEPTH   = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lnk_den,
  input  logic [DATA_W-1:0] lnk_dat,
  output logic              lnk_fc,
  input  logic              rd_en,
  output logic              rd_vld,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_first,
  output logic              rd_last,
  input  logic              ovf_clr,
  output logic              ovf_err
);

  localparam int MSG_WORDS = HDR_MAX + PAY_MAX;
  localparam int CNT_W     = $clog2(DEPTH + 1);

  logic              wr_vld;
  mark_t             wr_mark;
  logic [DATA_W-1:0] wr_data;
  mark_t             q_mark;
  logic [CNT_W-1:0]  q_used;

  lrx_sampler #(.DATA_W(DATA_W)) u_samp (
    .clk     (clk),
    .rst_n   (rst_n),
    .lnk_den (lnk_den),
    .lnk_dat (lnk_dat),
    .wr_vld  (wr_vld),
    .wr_mark (wr_mark),
    .wr_data (wr_data)
  );

  lrx_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_q (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (wr_vld),
    .push_mark (wr_mark),
    .push_data (wr_data),
    .pop_req   (rd_en),
    .ovf_clr   (ovf_clr),
    .q_vld     (rd_vld),
    .q_mark    (q_mark),
    .q_data    (rd_data),
    .used      (q_used),
    .ovf       (ovf_err)
  );

  lrx_flow #(.DEPTH(DEPTH), .MSG_WORDS(MSG_WORDS)) u_fc (
    .used (q_used),
    .xon  (lnk_fc)
  );

  assign rd_first = q_mark.first;
  assign rd_last  = q_mark.last;

  // R6
  xon_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_fc |-> (32'(q_used) + 32'(MSG_WORDS) <= 32'(DEPTH)));

  // R6
  xoff_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lnk_fc |-> (32'(q_used) + 32'(MSG_WORDS) > 32'(DEPTH)));

endmodule

// File: tb/emsg_link_rx_test.sv
`timescale 1ns/1ps
module emsg_link_rx_test;

  localparam int CLK_T = 10;
  localparam int HALF  = CLK_T / 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lnk_den = 1'b0;
  logic [31:0] lnk_dat = '0;
  logic        lnk_fc;
  logic        rd_en = 1'b0;
  logic        rd_vld;
  logic [31:0] rd_data;
  logic        rd_first, rd_last;
  logic        ovf_clr = 1'b0;
  logic        ovf_err;

  int vecs = 0;
  int errs = 0;

  always #HALF clk = ~clk;

  emsg_link_rx uut (
    .clk(clk), .rst_n(rst_n), .lnk_den(lnk_den), .lnk_dat(lnk_dat),
    .lnk_fc(lnk_fc), .rd_en(rd_en), .rd_vld(rd_vld), .rd_data(rd_data),
    .rd_first(rd_first), .rd_last(rd_last), .ovf_clr(ovf_clr), .ovf_err(ovf_err)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one word slot; data is valid only around the falling edge (R1)
  task automatic drive_word(logic den, logic [31:0] d);
    @(posedge clk);
    #1 lnk_den = den;
    lnk_dat = 32'hBAD0_BAD0;
    #(HALF - 2) lnk_dat = d;
    #2 lnk_dat = ~d;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive_word(1'b0, 32'h0);
  endtask

  task automatic send_msg(int n, logic [31:0] base);
    for (int i = 0; i < n; i++) drive_word(i < n - 1, base + 32'(i));
  endtask

  task automatic pop_check(string req, logic [31:0] d, logic f, logic l);
    @(negedge clk);
    check(req, rd_vld, 1);
    check(req, rd_data, d);
    check(req, {rd_first, rd_last}, {f, l});
    rd_en = 1'b1;
    @(posedge clk);
    #1 rd_en = 1'b0;
  endtask

  task automatic drain(output int n, output logic [31:0] ld, output logic ll);
    n = 0; ld = '0; ll = 1'b0;
    @(negedge clk);
    while (rd_vld) begin
      ld = rd_data; ll = rd_last;
      rd_en = 1'b1;
      @(posedge clk);
      #1 rd_en = 1'b0;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R9 empty", rd_vld, 0);
    check("R9 fc", lnk_fc, 1);
    check("R9 ovf", ovf_err, 0);
  endtask

  task automatic t_single();
    send_msg(3, 32'hA000_0010);
    idle(1);
    pop_check("R1 R2 first word", 32'hA000_0010, 1, 0);
    pop_check("R3 middle word", 32'hA000_0011, 0, 0);
    pop_check("R3 last word", 32'hA000_0012, 0, 1);
    @(negedge clk);
    check("R7 empty after msg", rd_vld, 0);
  endtask

  task automatic t_back2back();
    send_msg(3, 32'hB000_0000);
    send_msg(2, 32'hB100_0000);
    idle(1);
    pop_check("R4 m1 w0", 32'hB000_0000, 1, 0);
    pop_check("R4 m1 w1", 32'hB000_0001, 0, 0);
    pop_check("R4 m1 w2", 32'hB000_0002, 0, 1);
    pop_check("R4 m2 w0", 32'hB100_0000, 1, 0);
    pop_check("R4 m2 w1", 32'hB100_0001, 0, 1);
  endtask

  task automatic t_idle();
    idle(6);
    @(negedge clk);
    check("R5 idle stores nothing", rd_vld, 0);
  endtask

  task automatic t_flow();
    int n; logic [31:0] ld; logic ll;
    send_msg(60, 32'hC000_0000);
    idle(1);
    @(negedge clk);
    check("R6 fc at 60 used", lnk_fc, 1);
    send_msg(2, 32'hC100_0000);
    idle(1);
    @(negedge clk);
    check("R6 fc at 62 used", lnk_fc, 0);
    pop_check("R7 order w0", 32'hC000_0000, 1, 0);
    @(negedge clk);
    check("R6 fc at 61 used", lnk_fc, 0);
    pop_check("R7 order w1", 32'hC000_0001, 0, 0);
    @(negedge clk);
    check("R6 fc back at 60 used", lnk_fc, 1);
    drain(n, ld, ll);
    check("R7 drained count", n, 60);
    check("R7 drained tail", {ll, ld}, {1'b1, 32'hC100_0001});
  endtask

  task automatic t_overflow();
    int n; logic [31:0] ld; logic ll;
    send_msg(130, 32'hD000_0000);
    idle(1);
    @(negedge clk);
    check("R8 ovf set", ovf_err, 1);
    check("R6 fc when full", lnk_fc, 0);
    idle(3);
    @(negedge clk);
    check("R8 ovf sticky", ovf_err, 1);
    pop_check("R8 kept head", 32'hD000_0000, 1, 0);
    drain(n, ld, ll);
    check("R8 kept count", n, 127);
    check("R8 dropped tail", {ll, ld}, {1'b0, 32'hD000_007F});
    check("R8 ovf kept after drain", ovf_err, 1);
    @(posedge clk);
    #1 ovf_clr = 1'b1;
    @(posedge clk);
    #1 ovf_clr = 1'b0;
    @(negedge clk);
    check("R8 ovf cleared", ovf_err, 0);
    check("R6 fc when empty", lnk_fc, 1);
  endtask

  task automatic t_reset_midway();
    send_msg(4, 32'hE000_0000);
    idle(1);
    @(posedge clk);
    #1 rst_n = 1'b0;
    #(CLK_T * 2) rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset empties", rd_vld, 0);
    check("R9 reset fc", lnk_fc, 1);
  endtask

  initial begin
    #(CLK_T * 200000);
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #(CLK_T * 3 + 1) rst_n = 1'b1;
    t_reset();
    t_single();
    t_back2back();
    t_idle();
    t_flow();
    t_overflow();
    t_reset_midway();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule